// File: doc/BRIEF.md
# Serial Bus Collision Detector

This block watches a clock-synchronous serial transmitter and tells when another device has pulled the shared line low while the transmitter was releasing it. At each sampling event the bit being driven on the transmit line is compared with the receive line, after the receive line has been brought into the system clock domain. The sampling event is either a rising edge of the transfer clock or a pulse from an external timer underflow, chosen by a control bit.

A detected collision raises a one-cycle pulse. It also feeds a sticky arbitration-lost flag, which is updated either on every bit or once per byte at a byte-boundary strobe. The block holds the transmit-enable bit. Software sets and clears it with pulses, and the bit can also be cleared automatically on a collision. A transmit-start strobe is issued when transmission is enabled, either at once or only after a falling edge on the receive line.

The shift register, baud generation and start/stop condition detection belong to neighbouring logic.

Top module: `bus_collision_monitor`

## Requirements
- R1: After reset, arbLost, collisionPulse, txEnOut and txStart are all 0.
- R2: A collision is a sampling event at which txd is 1 and the receive level is 0, where rxd passes through a two-flop synchronizer before it is compared. Each collision gives exactly one collisionPulse, in the cycle after the sampling event. The other three txd/rxd combinations give none.
- R3: With sampleSel = 0, a sampling event is a rising edge of xferClk. Pulses on timerUflow then cause no collision.
- R4: With sampleSel = 1, a sampling event is a timerUflow pulse. Rising edges of xferClk then cause no collision.
- R5: With byteMode = 0, arbLost is 1 in the cycle after a colliding sampling event.
- R6: With byteMode = 1, arbLost does not change until byteDone. At byteDone it becomes 1 if any sampling event since the previous byteDone, including one in the same cycle, collided. The collision record is then emptied.
- R7: arbLost is sticky and clears only on flagClr. A flag set in the same cycle as flagClr takes priority, so arbLost stays 1.
- R8: txEnSet sets txEnOut and txEnClr clears it. With autoClrEn = 1, a collision clears txEnOut in the same cycle that collisionPulse rises. With autoClrEn = 0, txEnOut is unaffected by collisions.
- R9: With startOnFall = 0, txEnSet gives one txStart pulse in the next cycle.
- R10: With startOnFall = 1, txEnSet gives no txStart. Instead, one txStart pulse follows the first falling edge of the synchronized receive line while txEnOut is still 1.
- R11: collisionPulse lasts one clock cycle for each collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| xferClk | input | 1 | Transfer clock level, synchronous to clk |
| timerUflow | input | 1 | One-cycle timer underflow pulse |
| txd | input | 1 | Bit currently driven by the transmitter (1 = released) |
| rxd | input | 1 | Receive line level, asynchronous |
| byteDone | input | 1 | Byte-boundary strobe |
| sampleSel | input | 1 | 0: sample on xferClk rise, 1: sample on timerUflow |
| byteMode | input | 1 | 0: flag updates per bit, 1: per byte |
| autoClrEn | input | 1 | 1: a collision clears the transmit enable |
| startOnFall | input | 1 | 1: transmit start waits for an rxd falling edge |
| flagClr | input | 1 | Software clear pulse for arbLost |
| txEnSet | input | 1 | Software pulse setting the transmit enable |
| txEnClr | input | 1 | Software pulse clearing the transmit enable |
| arbLost | output | 1 | Sticky arbitration-lost flag |
| collisionPulse | output | 1 | One-cycle collision indication |
| txEnOut | output | 1 | Transmit-enable bit after gating |
| txStart | output | 1 | One-cycle transmit-start strobe |

## Verification
The comparison is driven with all four txd/rxd pairings, both through directed bits and through random bytes. Only the released-high, read-low pairing may produce a pulse, which separates a correct compare from an inverted or XOR-style one. Each sampling source is also fed the other source's pulse, which shows whether the select bit really masks it. Random bytes are run in both update modes, so a flag that moves before the byte strobe, or that misses a collision early in the byte, shows up as a difference. Directed cases cover a clear that coincides with a collision, auto-clear on and off, and the two transmit-start paths.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef struct packed {
    logic sampleHit;
    logic collide;
    logic rxFall;
  } bcd_strobes_t;
endpackage

// File: rtl/bcd_datapath.sv
module bcd_datapath
  import bcd_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         xferClk,
  input  logic         timerUflow,
  input  logic         sampleSel,
  input  logic         txd,
  input  logic         rxd,
  output bcd_strobes_t strobes
);
  localparam int LastStage = SyncStages - 1;

  logic [LastStage:0] rxSync;
  logic rxPrev;
  logic xferPrev;
  logic rxSafe;
  logic xferRise;
  logic sampleEv;

  // receive synchronizer, one flop per stage; idles high
  for (genvar s = 0; s < SyncStages; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) rxSync[s] <= 1'b1;
        else       rxSync[s] <= rxd;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) rxSync[s] <= 1'b1;
        else       rxSync[s] <= rxSync[s-1];
    end
  end

  assign rxSafe = rxSync[LastStage];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPrev   <= 1'b1;
      xferPrev <= 1'b1;
    end else begin
      rxPrev   <= rxSafe;
      xferPrev <= xferClk;
    end
  end

  assign xferRise = xferClk & ~xferPrev;
  assign sampleEv = sampleSel ? timerUflow : xferRise;

  always_comb begin
    strobes.sampleHit = sampleEv;
    strobes.collide   = sampleEv & txd & ~rxSafe;
    strobes.rxFall    = rxPrev & ~rxSafe;
  end
endmodule

// File: rtl/bcd_control.sv
module bcd_control
  import bcd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  bcd_strobes_t strobes,
  input  logic         byteDone,
  input  logic         byteMode,
  input  logic         autoClrEn,
  input  logic         startOnFall,
  input  logic         flagClr,
  input  logic         txEnSet,
  input  logic         txEnClr,
  output logic         arbLost,
  output logic         collisionPulse,
  output logic         txEnOut,
  output logic         txStart
);
  logic byteAcc;
  logic armed;
  logic flagSet;
  logic enKill;
  logic startNow;

  assign flagSet  = byteMode ? (byteDone & (byteAcc | strobes.collide))
                             : strobes.collide;
  assign enKill   = (strobes.collide & autoClrEn) | txEnClr;
  assign startNow = (txEnSet & ~startOnFall)
                  | (armed & strobes.rxFall & txEnOut);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arbLost        <= 1'b0;
      byteAcc        <= 1'b0;
      collisionPulse <= 1'b0;
      txEnOut        <= 1'b0;
      armed          <= 1'b0;
      txStart        <= 1'b0;
    end else begin
      arbLost        <= (arbLost & ~flagClr) | flagSet;
      collisionPulse <= strobes.collide;
      txStart        <= startNow;

      if (byteDone || !byteMode) byteAcc <= 1'b0;
      else                       byteAcc <= byteAcc | strobes.collide;

      if (enKill)       txEnOut <= 1'b0;
      else if (txEnSet) txEnOut <= 1'b1;

      if (enKill)                        armed <= 1'b0;
      else if (txEnSet && startOnFall)   armed <= 1'b1;
      else if (armed && strobes.rxFall)  armed <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_collision_monitor.sv
module bus_collision_monitor
  import bcd_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic xferClk,
  input  logic timerUflow,
  input  logic txd,
  input  logic rxd,
  input  logic byteDone,
  input  logic sampleSel,
  input  logic byteMode,
  input  logic autoClrEn,
  input  logic startOnFall,
  input  logic flagClr,
  input  logic txEnSet,
  input  logic txEnClr,
  output logic arbLost,
  output logic collisionPulse,
  output logic txEnOut,
  output logic txStart
);
  bcd_strobes_t strobes;

  bcd_datapath #(.SyncStages(SyncStages)) u_dp (
    .clk(clk), .rstN(rstN), .xferClk(xferClk), .timerUflow(timerUflow),
    .sampleSel(sampleSel), .txd(txd), .rxd(rxd), .strobes(strobes)
  );

  bcd_control u_ctl (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteDone(byteDone),
    .byteMode(byteMode), .autoClrEn(autoClrEn), .startOnFall(startOnFall),
    .flagClr(flagClr), .txEnSet(txEnSet), .txEnClr(txEnClr),
    .arbLost(arbLost), .collisionPulse(collisionPulse),
    .txEnOut(txEnOut), .txStart(txStart)
  );
endmodule

// File: rtl/bcd_checker.sv
module bcd_checker (
  input logic clk,
  input logic rstN,
  input logic byteDone,
  input logic byteMode,
  input logic autoClrEn,
  input logic startOnFall,
  input logic flagClr,
  input logic txEnSet,
  input logic arbLost,
  input logic collisionPulse,
  input logic txEnOut,
  input logic txStart
);
  // R7: flag holds unless cleared
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    arbLost && !flagClr |=> arbLost);

  // R5: per-bit mode raises the flag together with the pulse
  p_perbit_r5: assert property (@(posedge clk) disable iff (!rstN)
    collisionPulse && !$past(byteMode) |-> arbLost);

  // R6: per-byte mode never raises the flag off the byte strobe
  p_bytehold_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(byteMode) && !$past(byteDone) && !$past(arbLost) |-> !arbLost);

  // R8: auto-clear drops the enable with the collision pulse
  p_autoclr_r8: assert property (@(posedge clk) disable iff (!rstN)
    collisionPulse && $past(autoClrEn) |-> !txEnOut);

  // R9: ordinary start follows the enable write
  p_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(txEnSet) && !$past(startOnFall) |-> txStart);

  // R1: outputs quiet while reset is held
  always @(posedge clk)
    if (!rstN) begin
      a_reset_r1: assert (!arbLost && !txEnOut && !txStart);
    end
endmodule

bind bus_collision_monitor bcd_checker u_chk (
  .clk(clk), .rstN(rstN), .byteDone(byteDone), .byteMode(byteMode),
  .autoClrEn(autoClrEn), .startOnFall(startOnFall), .flagClr(flagClr),
  .txEnSet(txEnSet), .arbLost(arbLost), .collisionPulse(collisionPulse),
  .txEnOut(txEnOut), .txStart(txStart)
);

// File: tb/tb_bus_collision_monitor.sv
`timescale 1ns/1ps
module tb_bus_collision_monitor;
  logic clk = 0, rstN = 0;
  logic xferClk = 0, timerUflow = 0, txd = 1, rxd = 1, byteDone = 0;
  logic sampleSel = 0, byteMode = 0, autoClrEn = 0, startOnFall = 0;
  logic flagClr = 0, txEnSet = 0, txEnClr = 0;
  logic arbLost, collisionPulse, txEnOut, txStart;

  int testCnt = 0, failCnt = 0;
  int collCnt = 0, startCnt = 0;

  always #10 clk = ~clk;

  bus_collision_monitor dut (.*);

  always @(negedge clk) begin
    if (collisionPulse) collCnt++;
    if (txStart) startCnt++;
  end

  function automatic int expColl(input logic t, input logic r);
    return (t && !r) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one bit: set lines, let rxd settle, fire a sampling source, read two negedges on
  task automatic doBit(input logic t, input logic r, input logic useTimer,
                       output int pulses);
    int c0;
    @(negedge clk); txd = t; rxd = r;
    repeat (2) @(negedge clk);
    c0 = collCnt;
    if (useTimer) timerUflow = 1; else xferClk = 1;
    @(negedge clk); timerUflow = 0; xferClk = 0;
    @(negedge clk);
    pulses = collCnt - c0;
  endtask

  task automatic pulseSig(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    int p, c0, s0;
    logic anyColl;
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    chk("R1 arbLost", arbLost, 0);
    chk("R1 txEnOut", txEnOut, 0);
    chk("R1 txStart", txStart, 0);
    chk("R1 collisionPulse", collisionPulse, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R2 / R3: the four pairings on xferClk sampling
    for (int k = 0; k < 4; k++) begin
      doBit(k[1], k[0], 0, p);
      chk("R2 pairing pulses", p, expColl(k[1], k[0]));
    end
    chk("R5 flag after collision", arbLost, 1);
    pulseSig(flagClr);
    chk("R7 clear", arbLost, 0);

    // R3: timer pulse ignored when sampling on transfer clock
    doBit(1, 0, 1, p);
    chk("R3 timer ignored", p, 0);
    chk("R3 flag untouched", arbLost, 0);

    // R4: timer sampling, xferClk ignored
    sampleSel = 1;
    doBit(1, 0, 0, p);
    chk("R4 xferClk ignored", p, 0);
    doBit(1, 0, 1, p);
    chk("R4 timer samples", p, 1);
    doBit(1, 1, 1, p);
    chk("R4 no collision when high", p, 0);
    sampleSel = 0;

    // R7: clear coinciding with a collision keeps the flag
    @(negedge clk); txd = 1; rxd = 0;
    repeat (2) @(negedge clk);
    xferClk = 1; flagClr = 1;
    @(negedge clk); xferClk = 0; flagClr = 0;
    @(negedge clk);
    chk("R7 set wins over clear", arbLost, 1);
    repeat (3) @(negedge clk);
    chk("R7 sticky", arbLost, 1);
    pulseSig(flagClr);
    chk("R7 cleared", arbLost, 0);

    // R11: exactly one pulse per collision
    c0 = collCnt;
    doBit(1, 0, 0, p);
    repeat (3) @(negedge clk);
    chk("R11 single pulse", collCnt - c0, 1);
    pulseSig(flagClr);

    // R5 / R6 random bytes in both modes
    for (int b = 0; b < 12; b++) begin
      logic bm, ss;
      bm = 1'($urandom % 2);
      ss = 1'($urandom % 2);
      byteMode = bm; sampleSel = ss;
      pulseSig(flagClr);
      anyColl = 0;
      for (int i = 0; i < 8; i++) begin
        logic t, r;
        t = 1'($urandom % 2);
        r = ($urandom % 4) != 0;
        doBit(t, r, ss, p);
        chk("R2 random bit", p, expColl(t, r));
        anyColl = anyColl | (expColl(t, r) == 1);
        if (bm) chk("R6 flag held inside byte", arbLost, 0);
        else    chk("R5 per-bit flag", arbLost, anyColl);
      end
      pulseSig(byteDone);
      chk("R6 flag after byte", arbLost, anyColl);
    end

    // R6: record emptied at byteDone
    byteMode = 1; sampleSel = 0;
    pulseSig(flagClr);
    doBit(1, 0, 0, p);
    pulseSig(byteDone);
    chk("R6 byte collision", arbLost, 1);
    pulseSig(flagClr);
    doBit(1, 1, 0, p);
    pulseSig(byteDone);
    chk("R6 record emptied", arbLost, 0);
    byteMode = 0;

    // R8: auto-clear on and off
    rxd = 1;
    autoClrEn = 1;
    pulseSig(txEnSet);
    chk("R8 enable set", txEnOut, 1);
    doBit(1, 0, 0, p);
    chk("R8 auto-cleared", txEnOut, 0);
    autoClrEn = 0;
    pulseSig(txEnSet);
    doBit(1, 0, 0, p);
    chk("R8 kept without auto-clear", txEnOut, 1);
    pulseSig(txEnClr);
    chk("R8 software clear", txEnOut, 0);
    pulseSig(flagClr);

    // R9: ordinary start
    rxd = 1; startOnFall = 0;
    repeat (3) @(negedge clk);
    s0 = startCnt;
    pulseSig(txEnSet);
    chk("R9 immediate start", startCnt - s0, 1);
    pulseSig(txEnClr);

    // R10: start waits for rxd fall
    startOnFall = 1;
    s0 = startCnt;
    pulseSig(txEnSet);
    repeat (5) @(negedge clk);
    chk("R10 no start before fall", startCnt - s0, 0);
    rxd = 0;
    repeat (5) @(negedge clk);
    chk("R10 start on fall", startCnt - s0, 1);
    rxd = 1; repeat (4) @(negedge clk);
    rxd = 0; repeat (4) @(negedge clk);
    chk("R10 one start only", startCnt - s0, 1);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule